// File: doc/BRIEF.md
# Write-Burst Read-Interrupt Mask Generator

This block sits in a memory controller that drives a 16-bit double-data-rate DRAM interface with one data-mask bit per byte lane. It follows each write burst of 2, 4 or 8 words, which take one, two or four clocks because two words move per clock. From the clock after the write command it drives a single output enable for the data and strobe pads for as long as the burst lasts. Alongside the controller's write data stream it produces the per-beat byte masks.

When the controller asks to read while a write burst is still streaming, the block picks the earliest legal read command cycle and holds the request off with a ready signal until that cycle is allowed. In the read command cycle it masks both data words of that clock, which are the word just before the read edge and the word just after it. From the next clock on it stops driving the bus. Read data returns three clocks after the read, so the bus is free at least two clocks before the data arrives. A parameter turns the interrupt feature off for fast clock grades. A read then waits until the write burst has fully drained.

Top module: `wr_intr_mask_gen`

## Requirements
- R1: After reset, with no request pending, `bus_oe`, `rd_cmd` and every `dm` bit are 0 and `rd_ready` is 1.
- R2: A `wr_cmd` sampled at a rising edge with `wr_bl` code 1, 2 or 3 (burst of 2, 4 or 8 words) starts a burst when the bus is idle and `rd_cmd` is low. `bus_oe` is then high for exactly 1, 2 or 4 clocks, starting in the next clock. Code 0 starts nothing.
- R3: A `wr_cmd` seen while `bus_oe` or `rd_cmd` is high is ignored: the running burst keeps its length and no new burst follows it.
- R4: `rd_ready` is low in every cycle in which `wr_cmd` is high, so a read command never lands on the clock right after an accepted write. The write-to-read spacing is at least 2 clocks.
- R5: A read is accepted at a rising edge where `rd_req` and `rd_ready` are both high. `rd_cmd` is high during the following clock, and only for accepted reads.
- R6: With the interrupt feature enabled, `rd_ready` depends only on `wr_cmd`. In a read command cycle `bus_oe` keeps its burst value, and from the next clock `bus_oe` is low until a new write starts.
- R7: In a read command cycle in which `bus_oe` is high, every `dm` bit is 1 regardless of `wr_be`.
- R8: In every other cycle, `dm` equals the inverse of `wr_be` while `bus_oe` is high and is 0 while it is low. The mask has no latency relative to its beat. Bit i (i < LANES) is the rising-edge word of byte lane i and bit LANES+i is the falling-edge word. Lane 0 is DQ0–DQ7 and lane 1 is DQ8–DQ15.
- R9: With the interrupt feature disabled, `rd_ready` is also low while two or more data clocks of the burst remain, counting the current one. The read command therefore follows the last data clock, and `bus_oe` is never high together with `rd_cmd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, all state on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_cmd | input | 1 | Write command issued in this clock |
| wr_bl | input | 2 | Burst length code: 1 = 2 words, 2 = 4, 3 = 8, 0 = none |
| rd_req | input | 1 | Controller wants to issue a read |
| rd_ready | output | 1 | A read requested now is accepted at the coming edge |
| rd_cmd | output | 1 | Read command cycle |
| wr_be | input | 2*LANES | Byte enables of the two words in this clock (rise lanes low, fall lanes high) |
| bus_oe | output | 1 | Output enable for the DQ and DQS pad drivers |
| dm | output | 2*LANES | Data-mask per word and lane, same layout as `wr_be` |

## Verification
A wrong remaining-clock count shows up as `bus_oe` ending a clock early or late, which is visible at the end of the first burst. With interrupts disabled it also moves the clock in which `rd_ready` rises. If the read-cycle flag is lost or mistimed, the clock after the read shows a `dm` value of not-all-ones or a bus still driven. Either is seen within one or two clocks of the first interrupting read. A model of both parameter variants, run beat by beat, compares every output in every clock, so any divergence is caught in the cycle it happens.

// File: rtl/wim_pkg.sv
package wim_pkg;

   localparam int unsigned MAX_BL = 8;
   localparam int unsigned CYC_W  = $clog2(MAX_BL / 2 + 1);

   typedef enum logic [1:0] {
      BL_NONE  = 2'd0,
      BL_TWO   = 2'd1,
      BL_FOUR  = 2'd2,
      BL_EIGHT = 2'd3
   } bl_code_e;

   // clocks of data for a burst code, two words per clock
   function automatic logic [CYC_W-1:0] bl_cycles(input logic [1:0] code);
      logic [CYC_W-1:0] n;
      case (bl_code_e'(code))
         BL_TWO:   n = CYC_W'(1);
         BL_FOUR:  n = CYC_W'(2);
         BL_EIGHT: n = CYC_W'(MAX_BL / 2);
         default:  n = '0;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/wim_burst_track.sv
module wim_burst_track
   import wim_pkg::*;
#(
   parameter int unsigned CW = CYC_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_cmd,
   input  logic [1:0]    wr_bl,
   input  logic          rd_cmd,
   output logic          wr_start,
   output logic          bus_oe,
   output logic [CW-1:0] cyc_left
);

   logic [CW-1:0] cnt_q, cnt_d;
   logic [CW-1:0] len;

   assign len      = bl_cycles(wr_bl);
   assign wr_start = wr_cmd && (cnt_q == '0) && !rd_cmd && (len != '0);

   always_comb begin
      if (wr_start)
         cnt_d = len;
      else if (rd_cmd)
         cnt_d = '0;                       // release the bus after the read clock
      else if (cnt_q != '0)
         cnt_d = cnt_q - CW'(1);
      else
         cnt_d = cnt_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else
         cnt_q <= cnt_d;
   end

   assign bus_oe   = (cnt_q != '0);
   assign cyc_left = cnt_q;

   // R3: a write during a running burst does not reload it
   p_no_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && !rd_cmd && cnt_q > CW'(1)) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/wim_rd_gate.sv
module wim_rd_gate
   import wim_pkg::*;
#(
   parameter bit          INTERRUPT_EN = 1'b1,
   parameter int unsigned CW           = CYC_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_cmd,
   input  logic          rd_req,
   input  logic [CW-1:0] cyc_left,
   output logic          rd_ready,
   output logic          rd_cmd
);

   generate
      if (INTERRUPT_EN) begin : g_interrupt
         // any clock after the write clock is at least two clocks later
         assign rd_ready = !wr_cmd;
      end else begin : g_drain
         assign rd_ready = !wr_cmd && (cyc_left <= CW'(1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         rd_cmd <= 1'b0;
      else
         rd_cmd <= rd_req && rd_ready;
   end

   // R5: a read command only follows a request
   p_cmd_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_cmd);

endmodule

// File: rtl/wim_mask_gen.sv
module wim_mask_gen #(
   parameter int unsigned LANES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_oe,
   input  logic               rd_cmd,
   input  logic [2*LANES-1:0] wr_be,
   output logic [2*LANES-1:0] dm
);

   localparam int unsigned NBITS = 2 * LANES;

   generate
      for (genvar i = 0; i < NBITS; i++) begin : g_bit
         assign dm[i] = bus_oe && (rd_cmd || !wr_be[i]);
      end
   endgenerate

   // R7: both words of the read clock are masked
   p_read_clock_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cmd && bus_oe) |-> (&dm));

   // R8: no mask while the pads are released
   p_idle_no_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe |-> (dm == '0));

endmodule

// File: rtl/wr_intr_mask_gen.sv
module wr_intr_mask_gen
   import wim_pkg::*;
#(
   parameter int unsigned LANES        = 2,
   parameter bit          INTERRUPT_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_cmd,
   input  logic [1:0]         wr_bl,
   input  logic               rd_req,
   output logic               rd_ready,
   output logic               rd_cmd,
   input  logic [2*LANES-1:0] wr_be,
   output logic               bus_oe,
   output logic [2*LANES-1:0] dm
);

   localparam int unsigned CW = CYC_W;

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("LANES must be at least 1");
      end
      if (MAX_BL != 8) begin : g_bad_bl
         $error("burst tracking assumes a largest burst of 8 words");
      end
   endgenerate

   logic          wr_start;
   logic [CW-1:0] cyc_left;

   wim_burst_track #(.CW(CW)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_cmd   (wr_cmd),
      .wr_bl    (wr_bl),
      .rd_cmd   (rd_cmd),
      .wr_start (wr_start),
      .bus_oe   (bus_oe),
      .cyc_left (cyc_left)
   );

   wim_rd_gate #(.INTERRUPT_EN(INTERRUPT_EN), .CW(CW)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_cmd   (wr_cmd),
      .rd_req   (rd_req),
      .cyc_left (cyc_left),
      .rd_ready (rd_ready),
      .rd_cmd   (rd_cmd)
   );

   wim_mask_gen #(.LANES(LANES)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .bus_oe (bus_oe),
      .rd_cmd (rd_cmd),
      .wr_be  (wr_be),
      .dm     (dm)
   );

   // R4: no read command on the clock right after an accepted write
   p_wr_rd_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |=> !rd_cmd);

   // R2: an accepted write drives the bus from the next clock
   p_burst_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |=> bus_oe);

   // R6: pads released in the clock after any read command
   p_release_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cmd |=> !bus_oe);

   generate
      if (!INTERRUPT_EN) begin : g_drain_chk
         // R9: without interrupts the read never overlaps write data
         p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
            rd_cmd |-> !bus_oe);
      end
   endgenerate

endmodule

// File: tb/wr_intr_mask_gen_bench.sv
`timescale 1ns/1ps
module wr_intr_mask_gen_bench;

   localparam int unsigned LANES = 2;
   localparam int unsigned NB    = 2 * LANES;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_cmd = 1'b0;
   logic [1:0]    wr_bl = 2'd0;
   logic          rd_req = 1'b0;
   logic [NB-1:0] wr_be = '1;

   logic          rdy_a, cmd_a, oe_a;
   logic [NB-1:0] dm_a;
   logic          rdy_b, cmd_b, oe_b;
   logic [NB-1:0] dm_b;

   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;
   bit          done  = 1'b0;

   // model state: index 0 = interrupt enabled, 1 = drain mode
   int unsigned m_cnt [2];
   bit          m_rd  [2];

   always #2 clk = ~clk;

   wr_intr_mask_gen #(.LANES(LANES), .INTERRUPT_EN(1'b1)) u_wr_intr_mask_gen (
      .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wr_bl(wr_bl), .rd_req(rd_req),
      .rd_ready(rdy_a), .rd_cmd(cmd_a), .wr_be(wr_be), .bus_oe(oe_a), .dm(dm_a));

   wr_intr_mask_gen #(.LANES(LANES), .INTERRUPT_EN(1'b0)) u_wr_intr_mask_gen_drain (
      .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wr_bl(wr_bl), .rd_req(rd_req),
      .rd_ready(rdy_b), .rd_cmd(cmd_b), .wr_be(wr_be), .bus_oe(oe_b), .dm(dm_b));

   function automatic int unsigned len_of(input logic [1:0] c);
      case (c)
         2'd1:    return 1;
         2'd2:    return 2;
         2'd3:    return 4;
         default: return 0;
      endcase
   endfunction

   function automatic bit exp_ready(input int k, input logic w);
      return !w && ((k == 0) || (m_cnt[k] <= 1));
   endfunction

   function automatic logic [NB-1:0] exp_dm(input int k, input logic [NB-1:0] be);
      if (m_cnt[k] == 0) return '0;
      if (m_rd[k])       return '1;
      return ~be;
   endfunction

   task automatic cmp(input string tag, input string what, input int k,
                      input logic [NB-1:0] act, input logic [NB-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s inst%0d: actual %b expected %b at %0t",
                  tag, what, k, act, exp, $time);
      end
   endtask

   // drive one clock at the falling edge, check, then advance the model
   task automatic step(input string tag, input logic w, input logic [1:0] bl,
                       input logic r, input logic [NB-1:0] be);
      bit acc [2];
      wr_cmd = w; wr_bl = bl; rd_req = r; wr_be = be;
      #1;
      for (int k = 0; k < 2; k++) begin
         logic a_oe, a_rdy, a_cmd;
         logic [NB-1:0] a_dm;
         a_oe  = (k == 0) ? oe_a  : oe_b;
         a_rdy = (k == 0) ? rdy_a : rdy_b;
         a_cmd = (k == 0) ? cmd_a : cmd_b;
         a_dm  = (k == 0) ? dm_a  : dm_b;
         cmp(tag, "bus_oe",   k, NB'(a_oe),  NB'(m_cnt[k] != 0));
         cmp(tag, "rd_ready", k, NB'(a_rdy), NB'(exp_ready(k, w)));
         cmp(tag, "rd_cmd",   k, NB'(a_cmd), NB'(m_rd[k]));
         cmp(tag, "dm",       k, a_dm,       exp_dm(k, be));
         acc[k] = r && exp_ready(k, w);
      end
      @(posedge clk);
      for (int k = 0; k < 2; k++) begin
         if (w && m_cnt[k] == 0 && !m_rd[k] && len_of(bl) != 0)
            m_cnt[k] = len_of(bl);
         else if (m_rd[k])
            m_cnt[k] = 0;
         else if (m_cnt[k] != 0)
            m_cnt[k] = m_cnt[k] - 1;
         m_rd[k] = acc[k];
      end
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int k = 0; k < 2; k++) begin m_cnt[k] = 0; m_rd[k] = 0; end
      void'($urandom(32'd20417));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: idle after reset
      step("R1", 0, 2'd0, 0, '1);
      step("R1", 0, 2'd0, 0, '1);

      // R2: each burst length, and code 0 starts nothing
      step("R2", 1, 2'd1, 0, 4'b1111);
      step("R2", 0, 2'd0, 0, 4'b0110);
      step("R2", 1, 2'd2, 0, 4'b1111);
      repeat (3) step("R2", 0, 2'd0, 0, 4'b1010);
      step("R2", 1, 2'd3, 0, 4'b1111);
      repeat (5) step("R2", 0, 2'd0, 0, 4'b0101);
      step("R2", 1, 2'd0, 0, 4'b1111);
      step("R2", 0, 2'd0, 0, 4'b1111);

      // R3: second write while the bus is driven is ignored
      step("R3", 1, 2'd3, 0, 4'b1111);
      step("R3", 1, 2'd1, 0, 4'b1111);
      step("R3", 1, 2'd2, 0, 4'b0011);
      repeat (4) step("R3", 0, 2'd0, 0, 4'b1111);

      // R4, R7, R6: read requested with the write, taken one clock later
      step("R4", 1, 2'd3, 1, 4'b1111);
      step("R6", 0, 2'd0, 1, 4'b1111);
      step("R7", 0, 2'd0, 0, 4'b1111);   // read clock: all masked
      step("R6", 0, 2'd0, 0, 4'b1111);   // pads released
      repeat (4) step("R6", 0, 2'd0, 0, 4'b1111);

      // R9: drain mode holds the read until the last data clock
      step("R9", 1, 2'd3, 0, 4'b1111);
      repeat (6) step("R9", 0, 2'd0, 1, 4'b1100);
      repeat (3) step("R9", 0, 2'd0, 0, 4'b1111);

      // R5: back-to-back reads on an idle bus
      repeat (3) step("R5", 0, 2'd0, 1, 4'b1111);
      step("R5", 0, 2'd0, 0, 4'b1111);

      // R8: random traffic with random byte enables
      for (int i = 0; i < 4000; i++) begin
         logic w, r;
         logic [1:0] bl;
         logic [NB-1:0] be;
         w  = ($urandom % 4) == 0;
         r  = ($urandom % 3) == 0;
         bl = 2'($urandom);
         be = NB'($urandom);
         step("R8", w, bl, r, be);
      end

      finish_run();
   end

endmodule